// File: doc/BRIEF.md
# Linked-List Transmit Descriptor Walker

This block is the fetch engine on the transmit side of a descriptor ring. Software fills 32-byte descriptors in a shared memory and links them into a chain. Each descriptor has a link field that names the descriptor to visit after it. Software publishes work by writing a per-ring producer index, which names the last descriptor of the chain. The engine keeps its own consumer index for each ring, which names the last descriptor it finished. It follows the link field out of that descriptor, one hop at a time, until its consumer index equals the producer index. The chain order is therefore set by software and does not have to follow array order. This lets a scheduler upstream of software retire slots in any order.

For each descriptor it visits, the engine reads the control, address and message words. It checks the ownership flag and presents length, address, drop flag and the 128-bit message on a valid/ready port. When that port accepts the descriptor, the engine writes the ownership flag back so that the slot returns to software. Two rings are served, and the higher-numbered ring has strict priority. A fault in a link field stops only the ring it belongs to, until software clears that ring. When a descriptor fails the ownership check, the ring waits until its producer index is written again.

Top module: `txw_walker_top`

## Requirements
- R1: After reset both consumer indices read 0, no error or ownership-wait flag is set, tx_valid is low and no memory access is made.
- R2: A ring has work while its consumer index differs from its producer index. The next descriptor is the one named by bits [11:0] of word 3 of the descriptor at the consumer index, not the next array slot. Work stops when the two indices match.
- R3: The memory word address is {ring, index, word}. Word 1 carries the ownership flag in bit 0, the drop flag in bit 1 and the length in bits [31:16]. Word 2 is the packet address, and words 4 to 7 are the message, with word 4 in the lowest 32 bits. These fields appear unchanged on tx_len, tx_drop, tx_addr and tx_msg.
- R4: When checking is enabled, each accepted descriptor has its word 1 rewritten with bit 0 set and every other bit kept.
- R5: While tx_valid is high and tx_ready is low, tx_valid and all tx fields stay unchanged on the next cycle.
- R6: When checking is enabled and a fetched descriptor already has bit 0 of word 1 set, nothing is sent and the consumer index does not move. The ring's wait flag is raised. The ring retries only when its producer index is written again, and that write clears the flag.
- R7: When own_chk_en is low, bit 0 of word 1 is ignored on fetch and no write is made to memory.
- R8: When both rings have work, every descriptor of ring 1 is sent before ring 0 is served again.
- R9: A link value of RING_DEPTH or more sets that ring's error flag and sends nothing. Producer writes do not clear the flag. A ring_clr pulse clears it and sets both of the ring's indices to 0.
- R10: After each accepted descriptor, the ring's consumer index equals that descriptor's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_chk_en | input | 1 | Enables the ownership check on fetch and the write-back of the flag |
| cpu_idx_wr | input | N_RING | Per-ring strobe that loads the producer index |
| cpu_idx_in | input | N_RING x 12 | Producer index values |
| ring_clr | input | N_RING | Per-ring clear of the error and wait flags and both indices |
| dma_idx_out | output | N_RING x 12 | Consumer index of each ring |
| ring_err | output | N_RING | Link fault flag per ring |
| ring_own_wait | output | N_RING | Ownership-wait flag per ring |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W | Word address {ring, index, word} |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read strobe |
| tx_valid | output | 1 | A descriptor is being presented |
| tx_ready | input | 1 | Downstream accepts the descriptor |
| tx_ring | output | RGW | Ring of the presented descriptor |
| tx_idx | output | 12 | Index of the presented descriptor |
| tx_len | output | 16 | Packet length |
| tx_addr | output | 32 | Packet address |
| tx_msg | output | 128 | Message words |
| tx_drop | output | 1 | Drop flag from the descriptor |

## Verification
The embedded properties check on every cycle the following:
- the hold rule on the transmit port;
- that a write to memory always carries the ownership bit and happens only when checking is enabled;
- that the error and wait flags stay set until their release conditions;
- that a consumer index moves only on a completion or a clear;
- that a presented index always lies inside the ring.

Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural model:
- the out-of-order chain walk;
- the field placement;
- the order between rings;
- the retry after a producer rewrite;
- recovery after a clear.

// File: rtl/txw_pkg.sv
package txw_pkg;
  localparam int IDX_W  = 12;
  localparam int WORD_W = 32;
  localparam int MSG_W  = 4 * WORD_W;

  localparam logic [2:0] WD_CTRL = 3'd1;
  localparam logic [2:0] WD_ADDR = 3'd2;
  localparam logic [2:0] WD_LINK = 3'd3;
  localparam logic [2:0] WD_MSG0 = 3'd4;
  localparam logic [2:0] WD_LAST = 3'd7;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_NEXT  = 2'd1,
    W_FETCH = 2'd2,
    W_SEND  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/txw_ring_ctrl.sv
module txw_ring_ctrl import txw_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cpu_wr,
  input  logic [IDX_W-1:0] cpu_val,
  input  logic             adv,
  input  logic [IDX_W-1:0] adv_idx,
  input  logic             err_set,
  input  logic             own_fail,
  output logic [IDX_W-1:0] dma_idx,
  output logic             err,
  output logic             waiting,
  output logic             pending
);
  logic [IDX_W-1:0] cpu_q, cpu_n, dma_q, dma_n;
  logic             err_q, err_n, wt_q, wt_n;

  always_comb begin
    cpu_n = cpu_q;
    dma_n = dma_q;
    err_n = err_q;
    wt_n  = wt_q;
    if (clr) begin
      cpu_n = '0;
      dma_n = '0;
      err_n = 1'b0;
      wt_n  = 1'b0;
    end else begin
      if (cpu_wr)   cpu_n = cpu_val;
      if (adv)      dma_n = adv_idx;
      if (err_set)  err_n = 1'b1;
      if (cpu_wr)   wt_n  = 1'b0;
      else if (own_fail) wt_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q <= '0;
      dma_q <= '0;
      err_q <= 1'b0;
      wt_q  <= 1'b0;
    end else begin
      cpu_q <= cpu_n;
      dma_q <= dma_n;
      err_q <= err_n;
      wt_q  <= wt_n;
    end
  end

  assign dma_idx = dma_q;
  assign err     = err_q;
  assign waiting = wt_q;
  assign pending = (cpu_q != dma_q) && !err_q && !wt_q;

  // R9: a link fault stays until the ring is cleared
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !clr |=> err_q);
  // R6: the ownership wait is left only through a producer write or a clear
  a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wt_q && !cpu_wr && !clr |=> wt_q);
  // R10: the consumer index moves only on a completion or a clear
  a_r10_dma_moves_on_adv: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !clr |=> $stable(dma_q));
endmodule

// File: rtl/txw_ring_pick.sv
module txw_ring_pick #(
  parameter  int N_RING = 2,
  localparam int SW     = (N_RING > 1) ? $clog2(N_RING) : 1
) (
  input  logic [N_RING-1:0] pend,
  output logic              vld,
  output logic [SW-1:0]     sel
);
  always_comb begin
    vld = |pend;
    sel = '0;
    for (int i = 0; i < N_RING; i++) begin
      if (pend[i]) sel = SW'(i);
    end
  end
endmodule

// File: rtl/txw_chain_fsm.sv
module txw_chain_fsm import txw_pkg::*; #(
  parameter  int RING_DEPTH = 16,
  parameter  int RGW        = 1,
  localparam int RW         = $clog2(RING_DEPTH),
  localparam int ADDR_W     = RGW + RW + 3,
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(RING_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic              start,
  input  logic [RGW-1:0]    start_ring,
  input  logic [IDX_W-1:0]  start_dma,
  input  logic              abort,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [RGW-1:0]    cur_ring,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [15:0]       tx_len,
  output logic [WORD_W-1:0] tx_addr,
  output logic [MSG_W-1:0]  tx_msg,
  output logic              tx_drop,
  output logic              ev_adv,
  output logic              ev_err,
  output logic              ev_own
);
  walk_st_e          st_q, st_n;
  logic [RGW-1:0]    cur_q, cur_n;
  logic [IDX_W-1:0]  nxt_q, nxt_n;
  logic [2:0]        beat_q, beat_n;
  logic [WORD_W-1:0] w1_q, w1_n, pa_q, pa_n;
  logic [MSG_W-1:0]  msg_q, msg_n;
  logic [RGW-1:0]    rd_ring;
  logic [IDX_W-1:0]  rd_idx;
  logic [2:0]        rd_word;
  logic              link_bad;

  assign link_bad = {1'b0, mem_rdata[IDX_W-1:0]} >= LIMIT;

  always_comb begin
    st_n    = st_q;
    cur_n   = cur_q;
    nxt_n   = nxt_q;
    beat_n  = beat_q;
    w1_n    = w1_q;
    pa_n    = pa_q;
    msg_n   = msg_q;
    mem_en  = 1'b0;
    mem_we  = 1'b0;
    rd_ring = cur_q;
    rd_idx  = nxt_q;
    rd_word = WD_CTRL;
    ev_adv  = 1'b0;
    ev_err  = 1'b0;
    ev_own  = 1'b0;
    unique case (st_q)
      W_IDLE: begin
        if (start) begin
          cur_n   = start_ring;
          rd_ring = start_ring;
          rd_idx  = start_dma;
          rd_word = WD_LINK;
          mem_en  = 1'b1;
          st_n    = W_NEXT;
        end
      end
      W_NEXT: begin
        if (abort) begin
          st_n = W_IDLE;
        end else if (link_bad) begin
          ev_err = 1'b1;
          st_n   = W_IDLE;
        end else begin
          nxt_n   = mem_rdata[IDX_W-1:0];
          rd_idx  = mem_rdata[IDX_W-1:0];
          rd_word = WD_CTRL;
          mem_en  = 1'b1;
          beat_n  = WD_CTRL;
          st_n    = W_FETCH;
        end
      end
      W_FETCH: begin
        if (abort) begin
          st_n = W_IDLE;
        end else begin
          if (beat_q == WD_CTRL)      w1_n = mem_rdata;
          else if (beat_q == WD_ADDR) pa_n = mem_rdata;
          else                        msg_n[beat_q[1:0]*WORD_W +: WORD_W] = mem_rdata;
          if (beat_q == WD_CTRL && chk_en && mem_rdata[0]) begin
            ev_own = 1'b1;
            st_n   = W_IDLE;
          end else if (beat_q == WD_LAST) begin
            st_n = W_SEND;
          end else begin
            if (beat_q == WD_CTRL)      beat_n = WD_ADDR;
            else if (beat_q == WD_ADDR) beat_n = WD_MSG0;
            else                        beat_n = beat_q + 3'd1;
            rd_word = beat_n;
            mem_en  = 1'b1;
          end
        end
      end
      W_SEND: begin
        if (abort) begin
          st_n = W_IDLE;
        end else if (tx_ready) begin
          ev_adv = 1'b1;
          if (chk_en) begin
            mem_en  = 1'b1;
            mem_we  = 1'b1;
            rd_word = WD_CTRL;
          end
          st_n = W_IDLE;
        end
      end
      default: st_n = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      cur_q  <= '0;
      nxt_q  <= '0;
      beat_q <= WD_CTRL;
      w1_q   <= '0;
      pa_q   <= '0;
      msg_q  <= '0;
    end else begin
      st_q   <= st_n;
      cur_q  <= cur_n;
      nxt_q  <= nxt_n;
      beat_q <= beat_n;
      w1_q   <= w1_n;
      pa_q   <= pa_n;
      msg_q  <= msg_n;
    end
  end

  assign mem_addr  = {rd_ring, rd_idx[RW-1:0], rd_word};
  assign mem_wdata = w1_q | {{(WORD_W-1){1'b0}}, 1'b1};
  assign tx_valid  = (st_q == W_SEND);
  assign cur_ring  = cur_q;
  assign cur_idx   = nxt_q;
  assign tx_len    = w1_q[31:16];
  assign tx_drop   = w1_q[1];
  assign tx_addr   = pa_q;
  assign tx_msg    = msg_q;

  // R5: a presented descriptor is held until accepted
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !abort |=> tx_valid && $stable(cur_idx) && $stable(tx_len)
                                        && $stable(tx_addr) && $stable(tx_msg));
  // R4 / R7: memory is written only to hand ownership back, and only when checking is on
  a_r4_write_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en && mem_wdata[0] && chk_en);
endmodule

// File: rtl/txw_walker_top.sv
module txw_walker_top import txw_pkg::*; #(
  parameter  int RING_DEPTH = 16,
  parameter  int N_RING     = 2,
  localparam int RW         = $clog2(RING_DEPTH),
  localparam int RGW        = (N_RING > 1) ? $clog2(N_RING) : 1,
  localparam int ADDR_W     = RGW + RW + 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         own_chk_en,
  input  logic [N_RING-1:0]            cpu_idx_wr,
  input  logic [N_RING-1:0][IDX_W-1:0] cpu_idx_in,
  input  logic [N_RING-1:0]            ring_clr,
  output logic [N_RING-1:0][IDX_W-1:0] dma_idx_out,
  output logic [N_RING-1:0]            ring_err,
  output logic [N_RING-1:0]            ring_own_wait,
  output logic                         mem_en,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [WORD_W-1:0]            mem_wdata,
  input  logic [WORD_W-1:0]            mem_rdata,
  output logic                         tx_valid,
  input  logic                         tx_ready,
  output logic [RGW-1:0]               tx_ring,
  output logic [IDX_W-1:0]             tx_idx,
  output logic [15:0]                  tx_len,
  output logic [WORD_W-1:0]            tx_addr,
  output logic [MSG_W-1:0]             tx_msg,
  output logic                         tx_drop
);
  logic [N_RING-1:0] pend, pend_ok;
  logic              pick_vld;
  logic [RGW-1:0]    pick_sel;
  logic [RGW-1:0]    cur_ring;
  logic [IDX_W-1:0]  cur_idx;
  logic              ev_adv, ev_err, ev_own, abort;

  for (genvar r = 0; r < N_RING; r++) begin : g_ring
    logic hit;
    assign hit = (cur_ring == RGW'(r));
    txw_ring_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ring_clr[r]),
      .cpu_wr   (cpu_idx_wr[r]),
      .cpu_val  (cpu_idx_in[r]),
      .adv      (ev_adv && hit),
      .adv_idx  (cur_idx),
      .err_set  (ev_err && hit),
      .own_fail (ev_own && hit),
      .dma_idx  (dma_idx_out[r]),
      .err      (ring_err[r]),
      .waiting  (ring_own_wait[r]),
      .pending  (pend[r])
    );
  end

  assign pend_ok = pend & ~ring_clr;
  assign abort   = ring_clr[cur_ring];

  txw_ring_pick #(.N_RING(N_RING)) u_pick (
    .pend (pend_ok),
    .vld  (pick_vld),
    .sel  (pick_sel)
  );

  txw_chain_fsm #(.RING_DEPTH(RING_DEPTH), .RGW(RGW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_en     (own_chk_en),
    .start      (pick_vld),
    .start_ring (pick_sel),
    .start_dma  (dma_idx_out[pick_sel]),
    .abort      (abort),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .cur_ring   (cur_ring),
    .cur_idx    (cur_idx),
    .tx_len     (tx_len),
    .tx_addr    (tx_addr),
    .tx_msg     (tx_msg),
    .tx_drop    (tx_drop),
    .ev_adv     (ev_adv),
    .ev_err     (ev_err),
    .ev_own     (ev_own)
  );

  assign tx_ring = cur_ring;
  assign tx_idx  = cur_idx;

  // R9: a presented descriptor index always lies inside the ring
  a_r9_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ({1'b0, tx_idx} < (IDX_W+1)'(RING_DEPTH)));
  // R9: a faulted ring is never presented
  a_r9_no_send_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> !ring_err[tx_ring]);
endmodule

// File: tb/txw_walker_test.sv
module txw_walker_test;
  localparam int DEPTH = 16;
  localparam int AW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             own_chk_en;
  logic [1:0]       cpu_idx_wr, ring_clr;
  logic [1:0][11:0] cpu_idx_in;
  logic [1:0][11:0] dma_idx_out;
  logic [1:0]       ring_err, ring_own_wait;
  logic             mem_en, mem_we;
  logic [AW-1:0]    mem_addr;
  logic [31:0]      mem_wdata, mem_rdata;
  logic             tx_valid, tx_ready;
  logic [0:0]       tx_ring;
  logic [11:0]      tx_idx;
  logic [15:0]      tx_len;
  logic [31:0]      tx_addr;
  logic [127:0]     tx_msg;
  logic             tx_drop;

  txw_walker_top #(.RING_DEPTH(DEPTH), .N_RING(2)) uut (
    .clk(clk), .rst_n(rst_n), .own_chk_en(own_chk_en),
    .cpu_idx_wr(cpu_idx_wr), .cpu_idx_in(cpu_idx_in), .ring_clr(ring_clr),
    .dma_idx_out(dma_idx_out), .ring_err(ring_err), .ring_own_wait(ring_own_wait),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_ring(tx_ring),
    .tx_idx(tx_idx), .tx_len(tx_len), .tx_addr(tx_addr), .tx_msg(tx_msg), .tx_drop(tx_drop)
  );

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] ram [0:255];
  int exp_q[$];
  logic [15:0]  e_len  [0:1][0:DEPTH-1];
  logic [31:0]  e_addr [0:1][0:DEPTH-1];
  logic [127:0] e_msg  [0:1][0:DEPTH-1];
  logic         e_drop [0:1][0:DEPTH-1];

  task automatic check(input bit ok, input string req, input string what);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  function automatic int wa(input int r, input int i, input int w);
    return r * 128 + i * 8 + w;
  endfunction

  function automatic logic [31:0] mword(input logic [31:0] a, input int k);
    return a ^ (32'h1111_1111 * (k + 1));
  endfunction

  // memory model: one access per cycle, read data one cycle later
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] = mem_wdata;
      else        mem_rdata <= ram[mem_addr];
    end
  end

  task automatic put_desc(input int r, input int i, input bit own, input bit drop,
                          input logic [15:0] len, input logic [31:0] a, input int link);
    ram[wa(r,i,0)] = 32'h0;
    ram[wa(r,i,1)] = {len, 14'h0, drop, own};
    ram[wa(r,i,2)] = a;
    ram[wa(r,i,3)] = 32'(link);
    for (int k = 0; k < 4; k++) ram[wa(r,i,4+k)] = mword(a, k);
    e_len[r][i]  = len;
    e_addr[r][i] = a;
    e_drop[r][i] = drop;
    e_msg[r][i]  = {mword(a,3), mword(a,2), mword(a,1), mword(a,0)};
  endtask

  task automatic set_link(input int r, input int i, input int link);
    ram[wa(r,i,3)] = 32'(link);
  endtask

  task automatic publish(input int r, input int v);
    @(negedge clk);
    cpu_idx_in[r] = 12'(v);
    cpu_idx_wr[r] = 1'b1;
    @(negedge clk);
    cpu_idx_wr = '0;
  endtask

  task automatic publish2(input int v0, input int v1);
    @(negedge clk);
    cpu_idx_in[0] = 12'(v0);
    cpu_idx_in[1] = 12'(v1);
    cpu_idx_wr = 2'b11;
    @(negedge clk);
    cpu_idx_wr = '0;
  endtask

  task automatic wait_quiet(input string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, req, $sformatf("pending sends act %0d exp 0", exp_q.size()));
  endtask

  // downstream port model and reference comparison on every falling edge
  int gap = 2;
  int wcnt = 0;
  bit held = 1'b0;
  logic [11:0]  h_idx;
  logic [15:0]  h_len;
  logic [31:0]  h_addr;
  logic [127:0] h_msg;
  always @(negedge clk) begin
    if (!rst_n) begin
      tx_ready = 1'b0;
      wcnt = 0;
      held = 1'b0;
    end else begin
      if (held)
        check(tx_valid && tx_idx == h_idx && tx_len == h_len && tx_addr == h_addr && tx_msg == h_msg,
              "R5", $sformatf("hold act v%0d idx %0d exp v1 idx %0d", tx_valid, tx_idx, h_idx));
      held = 1'b0;
      tx_ready = 1'b0;
      if (tx_valid) begin
        if (wcnt >= gap) begin
          tx_ready = 1'b1;
          wcnt = 0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R2", $sformatf("send ring %0d idx %0d exp none", tx_ring, tx_idx));
          end else begin
            int k;
            int r;
            int i;
            k = exp_q.pop_front();
            check(int'(tx_ring) == k / 4096 && int'(tx_idx) == k % 4096, "R2",
                  $sformatf("order act %0d/%0d exp %0d/%0d", tx_ring, tx_idx, k / 4096, k % 4096));
            r = int'(tx_ring);
            i = int'(tx_idx) % DEPTH;
            check(tx_len == e_len[r][i] && tx_addr == e_addr[r][i] && tx_msg == e_msg[r][i]
                  && tx_drop == e_drop[r][i], "R3",
                  $sformatf("fields act len %h addr %h drop %0d exp len %h addr %h drop %0d",
                            tx_len, tx_addr, tx_drop, e_len[r][i], e_addr[r][i], e_drop[r][i]));
          end
        end else begin
          wcnt++;
          held = 1'b1;
          h_idx = tx_idx;
          h_len = tx_len;
          h_addr = tx_addr;
          h_msg = tx_msg;
        end
      end
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R2", "watchdog act expired exp done");
    summary();
  end

  initial begin
    own_chk_en = 1'b1;
    cpu_idx_wr = '0;
    cpu_idx_in = '0;
    ring_clr   = '0;
    for (int a = 0; a < 256; a++) ram[a] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(dma_idx_out[0] == 0 && dma_idx_out[1] == 0, "R1",
          $sformatf("idx act %0d/%0d exp 0/0", dma_idx_out[0], dma_idx_out[1]));
    check(ring_err == 2'b00 && ring_own_wait == 2'b00 && !tx_valid && !mem_en, "R1",
          $sformatf("flags act err %b wt %b v %0d en %0d exp 0", ring_err, ring_own_wait, tx_valid, mem_en));

    // R2 R3 R4 R10: out-of-order chain 0 -> 5 -> 2 -> 9 on ring 0
    put_desc(0, 0, 1'b1, 1'b0, 16'h0000, 32'h0, 5);
    put_desc(0, 5, 1'b0, 1'b0, 16'h0040, 32'h1000_0500, 2);
    put_desc(0, 2, 1'b0, 1'b1, 16'h05EE, 32'h2000_0200, 9);
    put_desc(0, 9, 1'b0, 1'b0, 16'h0123, 32'h3000_0900, 3);
    exp_q.push_back(5); exp_q.push_back(2); exp_q.push_back(9);
    publish(0, 9);
    wait_quiet("R2");
    check(dma_idx_out[0] == 9, "R10", $sformatf("dma0 act %0d exp 9", dma_idx_out[0]));
    check(ram[wa(0,5,1)] == {16'h0040, 16'h0001}, "R4",
          $sformatf("word1 act %h exp %h", ram[wa(0,5,1)], {16'h0040, 16'h0001}));
    check(ram[wa(0,2,1)] == {16'h05EE, 16'h0003}, "R4",
          $sformatf("word1 act %h exp %h", ram[wa(0,2,1)], {16'h05EE, 16'h0003}));

    // R8: both rings published together, ring 1 drains first
    gap = 0;
    put_desc(0, 3, 1'b0, 1'b0, 16'h0011, 32'h4000_0300, 4);
    put_desc(0, 4, 1'b0, 1'b0, 16'h0022, 32'h4000_0400, 6);
    put_desc(1, 0, 1'b1, 1'b0, 16'h0000, 32'h0, 7);
    put_desc(1, 7, 1'b0, 1'b0, 16'h0033, 32'h5000_0700, 1);
    put_desc(1, 1, 1'b0, 1'b0, 16'h0044, 32'h5000_0100, 8);
    exp_q.push_back(4096 + 7); exp_q.push_back(4096 + 1);
    exp_q.push_back(3); exp_q.push_back(4);
    publish2(4, 1);
    wait_quiet("R8");
    check(dma_idx_out[0] == 4 && dma_idx_out[1] == 1, "R10",
          $sformatf("idx act %0d/%0d exp 4/1", dma_idx_out[0], dma_idx_out[1]));

    // R6: descriptor 6 still owned by software
    gap = 1;
    put_desc(0, 6, 1'b1, 1'b0, 16'h0055, 32'h6000_0600, 20);
    publish(0, 6);
    wait_quiet("R6");
    check(ring_own_wait == 2'b01 && dma_idx_out[0] == 4, "R6",
          $sformatf("act wt %b dma0 %0d exp 01 4", ring_own_wait, dma_idx_out[0]));
    ram[wa(0,6,1)] = {16'h0055, 16'h0000};
    exp_q.push_back(6);
    publish(0, 6);
    wait_quiet("R6");
    check(ring_own_wait == 2'b00 && dma_idx_out[0] == 6, "R6",
          $sformatf("retry act wt %b dma0 %0d exp 00 6", ring_own_wait, dma_idx_out[0]));

    // R7: checking disabled, flag ignored and memory untouched
    own_chk_en = 1'b0;
    put_desc(1, 8, 1'b1, 1'b0, 16'h0066, 32'h7000_0800, 2);
    exp_q.push_back(4096 + 8);
    publish(1, 8);
    wait_quiet("R7");
    check(ram[wa(1,8,1)] == {16'h0066, 16'h0001} && dma_idx_out[1] == 8, "R7",
          $sformatf("act word1 %h dma1 %0d exp %h 8", ram[wa(1,8,1)], dma_idx_out[1], {16'h0066, 16'h0001}));
    check(ring_own_wait == 2'b00, "R7", $sformatf("wt act %b exp 00", ring_own_wait));
    own_chk_en = 1'b1;

    // R9: link fault on ring 0 (descriptor 6 links to 20)
    publish(0, 11);
    wait_quiet("R9");
    check(ring_err == 2'b01 && dma_idx_out[0] == 6, "R9",
          $sformatf("act err %b dma0 %0d exp 01 6", ring_err, dma_idx_out[0]));
    publish(0, 11);
    wait_quiet("R9");
    check(ring_err == 2'b01, "R9", $sformatf("after rewrite act err %b exp 01", ring_err));
    @(negedge clk);
    ring_clr = 2'b01;
    @(negedge clk);
    ring_clr = 2'b00;
    @(negedge clk);
    check(ring_err == 2'b00 && dma_idx_out[0] == 0 && dma_idx_out[1] == 8, "R9",
          $sformatf("clear act err %b idx %0d/%0d exp 00 0/8", ring_err, dma_idx_out[0], dma_idx_out[1]));
    set_link(0, 0, 12);
    put_desc(0, 12, 1'b0, 1'b0, 16'h0077, 32'h8000_0C00, 0);
    exp_q.push_back(12);
    publish(0, 12);
    wait_quiet("R9");
    check(dma_idx_out[0] == 12 && ring_err == 2'b00, "R10",
          $sformatf("recover act dma0 %0d err %b exp 12 00", dma_idx_out[0], ring_err));

    summary();
  end
endmodule